// File: doc/BRIEF.md
# USB 2.0 Host Capability Register Decoder

This block serves the read-mostly capability region at the start of a USB 2.0 enhanced host controller's memory window. A simple target port presents one request per cycle: a dword index inside the window, read/write direction, four byte enables, write data and a lock qualifier. The address comparator sits outside the block and supplies a window-hit flag. One cycle later the block answers with a claim, with a master-abort indication, or with nothing, so that another target may take the cycle.

The window holds four items: the capability length (20h), the interface version (0100h), the structural parameters (reset 00104208h) and the capability parameters (00006871h). Only the structural parameters can change, and only while firmware holds the write-unlock input high. Two reset inputs are provided. The suspend-well reset restores every stored value. The soft reset stands for the controller reset and the D3-to-D0 reset. It clears only the response path and leaves the programmed structural parameters as they were.

Top module: `usbcap_regs`

## Requirements
- R1: After suspend-well reset, a full-width read returns 01000020h at dword 0, 00104208h at dword 1 and 00006871h at dword 2. Byte 1 of dword 0 is zero, and dwords 3 to 7 read zero.
- R2: Read data carries byte lane i (bits 8i+7:8i) only when byte enable i is set. Other lanes are zero, and the data is zero whenever no claim is given.
- R3: A request is claimed in the cycle after it is presented, with its read data in that same cycle. This happens exactly when request valid, window hit and memory enable are high, and the power state is not D3, the lock qualifier is low and soft reset is released.
- R4: With memory enable low, an access in the window gets neither claim nor abort and writes nothing.
- R5: In D3 with memory enable high, an access in the window gets an abort in the next cycle, with no claim, zero data and no register change.
- R6: A locked access is never claimed and never changes a register.
- R7: A claimed write to dword 1 updates a byte of the structural parameters only when the write-unlock input is high and that byte's enable is set. Without unlock the write leaves the value unchanged.
- R8: Writes to dwords other than 1 are claimed and have no effect on any read-back value.
- R9: Soft reset never changes the structural parameters. While it is low, no request is claimed or written.
- R10: Suspend-well reset returns the structural parameters to 00104208h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| susp_rst_n | input | 1 | Suspend-well reset, synchronous, active low |
| soft_rst_n | input | 1 | Controller / power-state-exit reset, synchronous, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | IDX_W (3) | Dword index within the window |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| req_lock | input | 1 | Request belongs to a locked sequence |
| bar_hit | input | 1 | Address falls in this block's window |
| mem_en | input | 1 | Memory-space enable from configuration |
| pwr_d3 | input | 1 | Function is in D3 |
| wr_unlock | input | 1 | Permits writes to the structural parameters |
| rsp_claim | output | 1 | Request of previous cycle accepted |
| rsp_abort | output | 1 | Request of previous cycle ended in master abort |
| rsp_rdata | output | 32 | Read data for a claimed read |

## Verification
Two pairs of events can land in the same cycle. The first pair is soft reset and an unlocked write to the structural parameters: the write must be dropped, and the value programmed earlier must read back unchanged after release. The second pair is the unlock and lock qualifiers on one write: the lock must win, and the value must stay put. Both are driven as directed cases, and the random phase also mixes lock, D3 and unlock freely. A bench model judges every cycle's claim, abort and data and checks each write by reading the value back.

// File: rtl/usbcap_pkg.sv
// Shared constants for the USB host capability register decoder.
// Assumes a 32-bit data path with four byte lanes.
package usbcap_pkg;
    localparam int LANES = 4;
    localparam logic [7:0]  CAPLEN_VAL  = 8'h20;
    localparam logic [15:0] IFVER_VAL   = 16'h0100;
    localparam logic [31:0] SPARAM_RST  = 32'h0010_4208;
    localparam logic [31:0] CPARAM_VAL  = 32'h0000_6871;
    localparam int DW_ID     = 0;
    localparam int DW_SPARAM = 1;
    localparam int DW_CPARAM = 2;
endpackage

// File: rtl/usbcap_access_gate.sv
// Decides per request whether it is claimed, master-aborted or left alone,
// and registers that decision for the response cycle.
// Assumes one request per cycle; the window match is computed outside.
module usbcap_access_gate (
    input  logic clk,
    input  logic susp_rst_n,
    input  logic soft_rst_n,
    input  logic req_valid,
    input  logic bar_hit,
    input  logic mem_en,
    input  logic pwr_d3,
    input  logic req_lock,
    output logic take_now,
    output logic claim_q,
    output logic abort_q
);
    logic decode_ok;
    logic abort_now;

    // Combinational decode of the enable, power and lock qualifiers.
    always_comb begin
        decode_ok = soft_rst_n && req_valid && bar_hit && mem_en;
        take_now  = decode_ok && !pwr_d3 && !req_lock;
        abort_now = decode_ok && pwr_d3;
    end

    // Register the response kind; either reset clears it.
    always_ff @(posedge clk) begin
        if (!susp_rst_n || !soft_rst_n) begin
            claim_q <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            claim_q <= take_now;
            abort_q <= abort_now;
        end
    end

    assert_claim_cause_R3: assert property (@(posedge clk) disable iff (!susp_rst_n)
        claim_q |-> $past(req_valid && bar_hit && mem_en && !pwr_d3 && !req_lock));
    assert_claim_abort_excl_R5: assert property (@(posedge clk) disable iff (!susp_rst_n)
        !(claim_q && abort_q));
    assert_memoff_silent_R4: assert property (@(posedge clk) disable iff (!susp_rst_n)
        (req_valid && !mem_en) |=> (!claim_q && !abort_q));
    assert_lock_refused_R6: assert property (@(posedge clk) disable iff (!susp_rst_n)
        req_lock |=> !claim_q);
endmodule

// File: rtl/usbcap_param_store.sv
// Holds the structural parameters register with per-byte write enables.
// Assumes writes are already qualified; only suspend-well reset clears it.
module usbcap_param_store
    import usbcap_pkg::*;
(
    input  logic                 clk,
    input  logic                 susp_rst_n,
    input  logic                 wr_en,
    input  logic [LANES-1:0]     wr_be,
    input  logic [8*LANES-1:0]   wr_data,
    output logic [8*LANES-1:0]   value
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Update one byte lane on a qualified write with its enable set.
        always_ff @(posedge clk) begin
            if (!susp_rst_n)
                value[8*g +: 8] <= SPARAM_RST[8*g +: 8];
            else if (wr_en && wr_be[g])
                value[8*g +: 8] <= wr_data[8*g +: 8];
        end
    end
endmodule

// File: rtl/usbcap_read_mux.sv
// Selects the capability dword for an index and masks unselected byte lanes.
// Assumes unimplemented indices read as zero.
module usbcap_read_mux
    import usbcap_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0]     idx,
    input  logic [LANES-1:0]     be,
    input  logic [8*LANES-1:0]   sparam,
    output logic [8*LANES-1:0]   data
);
    logic [8*LANES-1:0] raw;

    // Pick the dword at the requested index.
    always_comb begin
        if (idx == IDX_W'(DW_ID))
            raw = {IFVER_VAL, 8'h00, CAPLEN_VAL};
        else if (idx == IDX_W'(DW_SPARAM))
            raw = sparam;
        else if (idx == IDX_W'(DW_CPARAM))
            raw = CPARAM_VAL;
        else
            raw = '0;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign data[8*g +: 8] = be[g] ? raw[8*g +: 8] : 8'h00;
    end
endmodule

// File: rtl/usbcap_regs.sv
// Capability region of a USB 2.0 enhanced host controller behind a simple
// target port. Responds one cycle after each request.
// Assumes the window match (bar_hit) is supplied from outside.
module usbcap_regs
    import usbcap_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic               clk,
    input  logic               susp_rst_n,
    input  logic               soft_rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [IDX_W-1:0]   req_word,
    input  logic [3:0]         req_be,
    input  logic [31:0]        req_wdata,
    input  logic               req_lock,
    input  logic               bar_hit,
    input  logic               mem_en,
    input  logic               pwr_d3,
    input  logic               wr_unlock,
    output logic               rsp_claim,
    output logic               rsp_abort,
    output logic [31:0]        rsp_rdata
);
    logic        take_now;
    logic        sp_wr;
    logic [31:0] sparam;
    logic [31:0] rd_now;

    usbcap_access_gate u_gate (
        .clk        (clk),
        .susp_rst_n (susp_rst_n),
        .soft_rst_n (soft_rst_n),
        .req_valid  (req_valid),
        .bar_hit    (bar_hit),
        .mem_en     (mem_en),
        .pwr_d3     (pwr_d3),
        .req_lock   (req_lock),
        .take_now   (take_now),
        .claim_q    (rsp_claim),
        .abort_q    (rsp_abort)
    );

    // Qualify a structural parameters write: claimed, unlocked, right index.
    assign sp_wr = take_now && req_write && wr_unlock &&
                   (req_word == IDX_W'(DW_SPARAM));

    usbcap_param_store u_store (
        .clk        (clk),
        .susp_rst_n (susp_rst_n),
        .wr_en      (sp_wr),
        .wr_be      (req_be),
        .wr_data    (req_wdata),
        .value      (sparam)
    );

    usbcap_read_mux #(.IDX_W(IDX_W)) u_mux (
        .idx    (req_word),
        .be     (req_be),
        .sparam (sparam),
        .data   (rd_now)
    );

    // Register read data for claimed reads; zero otherwise.
    always_ff @(posedge clk) begin
        if (!susp_rst_n || !soft_rst_n)
            rsp_rdata <= '0;
        else if (take_now && !req_write)
            rsp_rdata <= rd_now;
        else
            rsp_rdata <= '0;
    end

    assert_no_unlock_hold_R7: assert property (@(posedge clk) disable iff (!susp_rst_n)
        !wr_unlock |=> $stable(sparam));
    assert_soft_keeps_R9: assert property (@(posedge clk) disable iff (!susp_rst_n)
        !soft_rst_n |=> $stable(sparam));
    assert_lock_no_write_R6: assert property (@(posedge clk) disable iff (!susp_rst_n)
        req_lock |=> $stable(sparam));
    assert_idle_data_R2: assert property (@(posedge clk) disable iff (!susp_rst_n)
        !rsp_claim |-> (rsp_rdata == '0));
endmodule

// File: tb/usbcap_regs_tb.sv
`timescale 1ns/1ps
module usbcap_regs_tb;
    logic clk = 1'b0;
    logic susp_rst_n = 1'b0, soft_rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, req_lock = 0;
    logic bar_hit = 0, mem_en = 0, pwr_d3 = 0, wr_unlock = 0;
    logic [2:0]  req_word = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic rsp_claim, rsp_abort;
    logic [31:0] rsp_rdata;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [31:0] m_sp = 32'h0010_4208;

    always #2.5 clk = ~clk;

    usbcap_regs u_dut (
        .clk(clk), .susp_rst_n(susp_rst_n), .soft_rst_n(soft_rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
        .req_be(req_be), .req_wdata(req_wdata), .req_lock(req_lock),
        .bar_hit(bar_hit), .mem_en(mem_en), .pwr_d3(pwr_d3),
        .wr_unlock(wr_unlock), .rsp_claim(rsp_claim), .rsp_abort(rsp_abort),
        .rsp_rdata(rsp_rdata)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] raw_of(logic [2:0] idx);
        case (idx)
            3'd0: return 32'h0100_0020;
            3'd1: return m_sp;
            3'd2: return 32'h0000_6871;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] lanes(logic [3:0] be, logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = be[i] ? v[8*i +: 8] : 8'h00;
        return r;
    endfunction

    // One request: driven at a falling edge, response checked at the next one.
    task automatic access(string tag, logic wr, logic [2:0] idx, logic [3:0] be,
                          logic [31:0] wd, logic lk, logic hit, logic men,
                          logic d3, logic unl);
        logic ok, take, ab;
        logic [31:0] exp_d, nsp;
        ok   = soft_rst_n && hit && men;
        take = ok && !d3 && !lk;
        ab   = ok && d3;
        exp_d = (take && !wr) ? lanes(be, raw_of(idx)) : 32'h0;
        nsp = m_sp;
        if (take && wr && unl && idx == 3'd1)
            for (int i = 0; i < 4; i++) if (be[i]) nsp[8*i +: 8] = wd[8*i +: 8];
        req_valid = 1; req_write = wr; req_word = idx; req_be = be;
        req_wdata = wd; req_lock = lk; bar_hit = hit; mem_en = men;
        pwr_d3 = d3; wr_unlock = unl;
        @(negedge clk);
        req_valid = 0; req_lock = 0; wr_unlock = 0;
        chk({tag, " claim"}, {31'b0, rsp_claim}, {31'b0, take});
        chk({tag, " abort"}, {31'b0, rsp_abort}, {31'b0, ab});
        chk({tag, " rdata"}, rsp_rdata, exp_d);
        m_sp = nsp;
    endtask

    task automatic rd(string tag, logic [2:0] idx);
        access(tag, 0, idx, 4'hF, 32'h0, 0, 1, 1, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R3 reset claim", {31'b0, rsp_claim}, 32'h0);
        chk("R2 reset data", rsp_rdata, 32'h0);
        susp_rst_n = 1; soft_rst_n = 1;
        @(negedge clk);
        // R1: default values and reserved/unimplemented offsets
        for (int i = 0; i < 8; i++) rd("R1 default", 3'(i));
        // R2: lane masking, including reserved byte 1 alone
        access("R2 mask", 0, 0, 4'b0010, 0, 0, 1, 1, 0, 0);
        access("R2 mask", 0, 1, 4'b1001, 0, 0, 1, 1, 0, 0);
        access("R2 mask", 0, 2, 4'b0110, 0, 0, 1, 1, 0, 0);
        // R3: no window hit
        access("R3 nohit", 0, 1, 4'hF, 0, 0, 0, 1, 0, 0);
        // R4: memory enable off, write attempt with unlock
        access("R4 memoff", 1, 1, 4'hF, 32'hDEAD_BEEF, 0, 1, 0, 0, 1);
        rd("R4 readback", 1);
        // R5: D3 write attempt
        access("R5 d3", 1, 1, 4'hF, 32'h1111_2222, 0, 1, 1, 1, 1);
        access("R5 d3 read", 0, 0, 4'hF, 0, 0, 1, 1, 1, 0);
        rd("R5 readback", 1);
        // R6: lock and unlock together on a write
        access("R6 lock", 1, 1, 4'hF, 32'h5555_AAAA, 1, 1, 1, 0, 1);
        rd("R6 readback", 1);
        // R7: write without unlock, then partial write with unlock
        access("R7 nounlock", 1, 1, 4'hF, 32'h7777_7777, 0, 1, 1, 0, 0);
        rd("R7 readback", 1);
        access("R7 partial", 1, 1, 4'b0101, 32'hA1B2_C3D4, 0, 1, 1, 0, 1);
        rd("R7 readback", 1);
        // R8: writes to read-only dwords
        access("R8 ro", 1, 0, 4'hF, 32'hFFFF_FFFF, 0, 1, 1, 0, 1);
        access("R8 ro", 1, 2, 4'hF, 32'h0, 0, 1, 1, 0, 1);
        rd("R8 readback", 0);
        rd("R8 readback", 2);
        // R9: soft reset coinciding with an unlocked write
        access("R9 set", 1, 1, 4'hF, 32'h0BAD_F00D, 0, 1, 1, 0, 1);
        soft_rst_n = 0;
        access("R9 during", 1, 1, 4'hF, 32'h1234_5678, 0, 1, 1, 0, 1);
        access("R9 during", 0, 1, 4'hF, 0, 0, 1, 1, 0, 0);
        soft_rst_n = 1;
        @(negedge clk);
        rd("R9 kept", 1);
        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic lk, hit, men, d3, unl, wr;
            lk  = ($urandom % 8) == 0;
            hit = ($urandom % 8) != 0;
            men = ($urandom % 8) != 0;
            d3  = ($urandom % 8) == 0;
            unl = $urandom % 2;
            wr  = $urandom % 2;
            access("R3 random", wr, 3'($urandom % 8), 4'($urandom), $urandom,
                   lk, hit, men, d3, unl);
        end
        // R10: suspend-well reset restores default
        access("R10 set", 1, 1, 4'hF, 32'hCAFE_0001, 0, 1, 1, 0, 1);
        susp_rst_n = 0;
        @(negedge clk);
        susp_rst_n = 1;
        m_sp = 32'h0010_4208;
        @(negedge clk);
        rd("R10 default", 1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule